// File: doc/BRIEF.md
# Dual-Channel Double-Buffered Converter Code Loader

This block is the synchronous register front end for two 16-bit digital-to-analog converter channels that share one 8-bit data bus. Each channel owns a 16-bit staging register, filled one byte at a time, and a 16-bit output register whose contents are the code sent to the converter. A 3-bit operation field is shared by both channels and picks what a write does. The write can stage a byte, stage a byte and pass it straight into the output register, or copy the whole staged word into the output register.

Each channel has its own active-low write strobe and active-low select. One bus cycle can therefore load channel A, channel B or both at once. Codes are two's complement: 0x7FFF is the most positive output, 0x8000 the most negative, and 0x0000 is zero volts. A shared synchronous clear drives both channels to 0x0000. The registers sample on the rising clock edge. Each clock cycle in which a channel's strobe and select are both low counts as one write action.

Top module: `dual_dac_loader`

## Requirements
- R1: After the asynchronous reset (rst_n low), both output codes read 0x0000 and both staging registers hold 0x0000.
- R2: When clear is high at a rising edge, both output codes and both staging registers become 0x0000 on that edge. Clear wins over any write in the same cycle.
- R3: Operation 3'b110 (op[2:0], with op[2] the first address bit) in a write cycle copies the channel's full 16-bit staging register into its output code.
- R4: Operation 3'b101 in a write cycle stores the bus byte into staging bits [15:8] and leaves the output code unchanged.
- R5: Operation 3'b011 in a write cycle stores the bus byte into staging bits [7:0] and leaves the output code unchanged.
- R6: Operation 3'b100 in a write cycle stores the bus byte into staging bits [15:8] and into output bits [15:8] on the same edge. Output bits [7:0] are kept.
- R7: Operation 3'b010 in a write cycle stores the bus byte into staging bits [7:0] and into output bits [7:0] on the same edge. Output bits [15:8] are kept.
- R8: A channel whose write strobe or select is high changes neither its staging register nor its output code.
- R9: Channel index 0 (A) and index 1 (B) each follow their own strobe and select. With both enabled, one cycle applies the same operation and byte to both.
- R10: Operations 3'b111, 3'b001 and 3'b000 change no register of either channel.
- R11: A write takes effect on the rising edge that samples it. A flow-through byte appears on the output one edge after it is driven, which is the same edge as the staging update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers sample on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous active-high clear of both channels |
| op | input | 3 | Operation field shared by both channels |
| bus_byte | input | 8 | Shared data byte |
| wr_n | input | 2 | Active-low write strobe, one bit per channel (bit 0 = A) |
| sel_n | input | 2 | Active-low channel select, one bit per channel (bit 0 = A) |
| dac_code | output | 2x16 | Output codes, packed; index 0 = channel A |

## Verification
The checker watches every cycle for the following. Clear zeroes both register sets. An unselected channel or an unused operation leaves everything still. Staging-only operations leave the output alone. A transfer copies the staging word seen one edge earlier. A flow-through byte lands in its half while the other half holds. The bench scenarios cover what the checker cannot see at that distance. A word assembled across several bus cycles must reach the output intact. Clear must also empty the staging registers, which shows up only when a later transfer produces zero. Loading both channels in one cycle, and the full-scale code patterns, are also shown by the bench.

// File: rtl/dacld_pkg.sv
package dacld_pkg;

  localparam logic [2:0] OP_XFER    = 3'b110;
  localparam logic [2:0] OP_HI_HOLD = 3'b101;
  localparam logic [2:0] OP_HI_THRU = 3'b100;
  localparam logic [2:0] OP_LO_HOLD = 3'b011;
  localparam logic [2:0] OP_LO_THRU = 3'b010;

  typedef struct packed {
    logic stage_hi;
    logic stage_lo;
    logic out_hi;
    logic out_lo;
    logic xfer;
  } act_t;

  function automatic act_t decode_op(input logic [2:0] code);
    act_t a;
    a = '0;
    case (code)
      OP_XFER:    a.xfer = 1'b1;
      OP_HI_HOLD: a.stage_hi = 1'b1;
      OP_HI_THRU: begin a.stage_hi = 1'b1; a.out_hi = 1'b1; end
      OP_LO_HOLD: a.stage_lo = 1'b1;
      OP_LO_THRU: begin a.stage_lo = 1'b1; a.out_lo = 1'b1; end
      default:    a = '0;
    endcase
    return a;
  endfunction

  function automatic logic strobe_active(input logic wr_n, input logic sel_n);
    return !wr_n && !sel_n;
  endfunction

endpackage

// File: rtl/dacld_decode.sv
module dacld_decode
  import dacld_pkg::*;
(
  input  logic [2:0] op,
  output act_t       act
);
  always_comb act = decode_op(op);
endmodule

// File: rtl/dacld_channel.sv
module dacld_channel
  import dacld_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int CODE_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              wr_n,
  input  logic              sel_n,
  input  act_t              act,
  input  logic [BYTE_W-1:0] bus_byte,
  output logic              wr_evt,
  output logic [CODE_W-1:0] stage_q,
  output logic [CODE_W-1:0] code_q
);

  assign wr_evt = strobe_active(wr_n, sel_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      code_q  <= '0;
    end else if (clear) begin
      stage_q <= '0;
      code_q  <= '0;
    end else if (wr_evt) begin
      if (act.stage_hi) stage_q[CODE_W-1:BYTE_W] <= bus_byte;
      if (act.stage_lo) stage_q[BYTE_W-1:0]      <= bus_byte;
      if (act.out_hi)   code_q[CODE_W-1:BYTE_W]  <= bus_byte;
      if (act.out_lo)   code_q[BYTE_W-1:0]       <= bus_byte;
      if (act.xfer)     code_q                   <= stage_q;
    end
  end

endmodule

// File: rtl/dual_dac_loader.sv
module dual_dac_loader
  import dacld_pkg::*;
#(
  parameter int CHANNELS = 2,
  parameter int BYTE_W   = 8,
  localparam int CODE_W  = 2 * BYTE_W
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           clear,
  input  logic [2:0]                     op,
  input  logic [BYTE_W-1:0]              bus_byte,
  input  logic [CHANNELS-1:0]            wr_n,
  input  logic [CHANNELS-1:0]            sel_n,
  output logic [CHANNELS-1:0][CODE_W-1:0] dac_code
);

  act_t                            act;
  logic [CHANNELS-1:0]             wr_evt;
  logic [CHANNELS-1:0][CODE_W-1:0] stage_word;

  dacld_decode u_dec (.op(op), .act(act));

  for (genvar g = 0; g < CHANNELS; g++) begin : g_ch
    dacld_channel #(.BYTE_W(BYTE_W)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (clear),
      .wr_n     (wr_n[g]),
      .sel_n    (sel_n[g]),
      .act      (act),
      .bus_byte (bus_byte),
      .wr_evt   (wr_evt[g]),
      .stage_q  (stage_word[g]),
      .code_q   (dac_code[g])
    );
  end

endmodule

// File: rtl/dacld_checker.sv
module dacld_checker #(
  parameter int CHANNELS = 2,
  parameter int BYTE_W   = 8,
  localparam int CODE_W  = 2 * BYTE_W
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           clear,
  input logic [2:0]                     op,
  input logic [BYTE_W-1:0]              bus_byte,
  input logic [CHANNELS-1:0]            wr_evt,
  input logic [CHANNELS-1:0][CODE_W-1:0] stage_word,
  input logic [CHANNELS-1:0][CODE_W-1:0] dac_code
);

  for (genvar g = 0; g < CHANNELS; g++) begin : g_chk
    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (dac_code[g] == '0) && (stage_word[g] == '0)); // R2
    AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_evt[g] && !clear) |=> $stable(dac_code[g]) && $stable(stage_word[g])); // R8
    AST_UNUSED_OP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_evt[g] && !clear && (op == 3'b111 || op == 3'b001 || op == 3'b000))
      |=> $stable(dac_code[g]) && $stable(stage_word[g])); // R10
    AST_XFER_COPY: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_evt[g] && !clear && op == 3'b110) |=> dac_code[g] == $past(stage_word[g])); // R3
    AST_STAGE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_evt[g] && !clear && (op == 3'b101 || op == 3'b011)) |=> $stable(dac_code[g])); // R4
    AST_HI_THRU: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_evt[g] && !clear && op == 3'b100)
      |=> (dac_code[g][CODE_W-1:BYTE_W] == $past(bus_byte))
          && $stable(dac_code[g][BYTE_W-1:0])); // R6
    AST_LO_THRU: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_evt[g] && !clear && op == 3'b010)
      |=> (dac_code[g][BYTE_W-1:0] == $past(bus_byte))
          && $stable(dac_code[g][CODE_W-1:BYTE_W])); // R7
  end

endmodule

bind dual_dac_loader dacld_checker #(.CHANNELS(CHANNELS), .BYTE_W(BYTE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .clear      (clear),
  .op         (op),
  .bus_byte   (bus_byte),
  .wr_evt     (wr_evt),
  .stage_word (stage_word),
  .dac_code   (dac_code)
);

// File: tb/sim_dual_dac_loader.sv
module sim_dual_dac_loader;

  localparam int CLK_PERIOD = 10;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             clear = 1'b0;
  logic [2:0]       op = 3'b000;
  logic [7:0]       bus_byte = 8'h00;
  logic [1:0]       wr_n = 2'b11;
  logic [1:0]       sel_n = 2'b11;
  logic [1:0][15:0] dac_code;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  typedef struct {
    int          due;
    logic [15:0] exp_a;
    logic [15:0] exp_b;
    string       tag;
  } item_t;

  item_t       sb[$];
  item_t       it;
  logic [15:0] m_stage [2];
  logic [15:0] m_code  [2];

  dual_dac_loader u0 (
    .clk(clk), .rst_n(rst_n), .clear(clear), .op(op), .bus_byte(bus_byte),
    .wr_n(wr_n), .sel_n(sel_n), .dac_code(dac_code)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic compare(input logic [15:0] act, input logic [15:0] exp, input string tag, input string ch);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s ch%s: actual %h expected %h", tag, ch, act, exp);
    end
  endtask

  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      it = sb.pop_front();
      compare(dac_code[0], it.exp_a, it.tag, "A");
      compare(dac_code[1], it.exp_b, it.tag, "B");
    end
  end

  task automatic bus_cycle(input logic [2:0] o, input logic [1:0] w, input logic [1:0] s,
                           input logic [7:0] d, input logic clr, input string tag);
    item_t e;
    @(negedge clk);
    op = o; wr_n = w; sel_n = s; bus_byte = d; clear = clr;
    for (int c = 0; c < 2; c++) begin
      if (clr) begin
        m_stage[c] = 16'h0000; m_code[c] = 16'h0000;
      end else if (!w[c] && !s[c]) begin
        case (o)
          3'b110: m_code[c] = m_stage[c];
          3'b101: m_stage[c][15:8] = d;
          3'b011: m_stage[c][7:0] = d;
          3'b100: begin m_stage[c][15:8] = d; m_code[c][15:8] = d; end
          3'b010: begin m_stage[c][7:0] = d; m_code[c][7:0] = d; end
          default: ;
        endcase
      end
    end
    e.due = cyc + 1; e.exp_a = m_code[0]; e.exp_b = m_code[1]; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    for (int c = 0; c < 2; c++) begin m_stage[c] = '0; m_code[c] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    bus_cycle(3'b000, 2'b11, 2'b11, 8'h00, 1'b0, "R1 reset state");
    // Word assembly on A, B untouched
    bus_cycle(3'b101, 2'b10, 2'b10, 8'h12, 1'b0, "R4 stage high A");
    bus_cycle(3'b011, 2'b10, 2'b10, 8'h34, 1'b0, "R5 stage low A");
    bus_cycle(3'b110, 2'b10, 2'b10, 8'h00, 1'b0, "R3 transfer A");
    // Flow-through on B, full scale patterns
    bus_cycle(3'b100, 2'b01, 2'b01, 8'h7F, 1'b0, "R6 R11 high thru B");
    bus_cycle(3'b010, 2'b01, 2'b01, 8'hFF, 1'b0, "R7 R11 low thru B");
    bus_cycle(3'b100, 2'b10, 2'b10, 8'h80, 1'b0, "R6 high thru A");
    bus_cycle(3'b010, 2'b10, 2'b10, 8'h00, 1'b0, "R7 low thru A");
    // Both channels in one cycle
    bus_cycle(3'b101, 2'b00, 2'b00, 8'hAB, 1'b0, "R9 stage high both");
    bus_cycle(3'b011, 2'b00, 2'b00, 8'hCD, 1'b0, "R9 stage low both");
    bus_cycle(3'b110, 2'b00, 2'b00, 8'h00, 1'b0, "R9 transfer both");
    // Strobe or select high blocks the channel
    bus_cycle(3'b101, 2'b10, 2'b10, 8'h55, 1'b0, "R4 stage high A 55");
    bus_cycle(3'b110, 2'b11, 2'b00, 8'h00, 1'b0, "R8 wr high");
    bus_cycle(3'b110, 2'b00, 2'b11, 8'h00, 1'b0, "R8 sel high");
    bus_cycle(3'b100, 2'b01, 2'b10, 8'h99, 1'b0, "R8 mixed enables");
    // Unused operations leave staging intact
    bus_cycle(3'b111, 2'b00, 2'b00, 8'hEE, 1'b0, "R10 op 111");
    bus_cycle(3'b001, 2'b00, 2'b00, 8'hEE, 1'b0, "R10 op 001");
    bus_cycle(3'b000, 2'b00, 2'b00, 8'hEE, 1'b0, "R10 op 000");
    bus_cycle(3'b110, 2'b00, 2'b00, 8'h00, 1'b0, "R10 transfer after unused");
    // Clear beats a concurrent write, empties staging
    bus_cycle(3'b100, 2'b00, 2'b00, 8'h77, 1'b1, "R2 clear with write");
    bus_cycle(3'b110, 2'b00, 2'b00, 8'h00, 1'b0, "R2 transfer after clear");
    bus_cycle(3'b010, 2'b00, 2'b00, 8'h01, 1'b0, "R7 low thru after clear");
    bus_cycle(3'b000, 2'b11, 2'b11, 8'h00, 1'b0, "R8 idle");
    repeat (3) @(negedge clk);
    summary();
    $finish;
  end

endmodule